// File: doc/BRIEF.md
# Punched-Card Column DMA Controller

This block sits between a column-serial punched-card reader and system memory. Software loads a memory address and a negative column count through four word-wide registers, then sets the start bit in the control register. The reader delivers each card column as a strobe with twelve zone bits. For every column, the block formats the zones and writes the result to memory through a simple request/acknowledge master port that can also return an error.

Two formats are offered. In word mode each column becomes a 16-bit word that holds the raw zones. In packed mode each column becomes one byte. The rows that may carry several punches keep one bit each, and the seven rows that may carry only one punch are reduced to a 3-bit number.

A transfer ends when the count reaches zero, or at the first formatting, timing or memory error. At that point the block sets ready, latches the error cause and, if enabled, pulses an interrupt request.

Top module: `card_dma_ctrl`

## Requirements
- R1: After reset: ready=1, start bit=0, interrupt enable=0, all error flags 0, count/address/buffer registers 0, `dma_req`=0, `irq`=0.
- R2: Register select 0=control/status, 1=column count, 2=address, 3=column buffer. Status bits: 15 error summary, 12 reader offline, 11 format error, 10 late, 9 memory error, 7 ready, 6 interrupt enable, 5:4 address extension, 3 reader online, 2 hopper fault, 1 packed mode, 0 start/busy. Bits 14, 13 and 8 read 0. Bits 12, 3 and 2 mirror the reader inputs, and writes to read-only bits have no effect.
- R3: Writing 1 to bit 0 while ready=1 starts a transfer: busy=1, ready=0, and all error flags are cleared. While busy, writes to the count, the address, the extension bits, the packed-mode bit and the start bit are ignored.
- R4: Zone encoding on `col_zones`: bit 11 = row 12, bit 10 = row 11, bit 9-k = row k for k=0..9. In word mode the DMA data is {4'b0, col_zones} and `dma_byte`=0.
- R5: In packed mode the DMA data is {8'b0, row12, row11, row0, row9, row8, code}. Here code (bits 2:0) is the number k of the one punched row among 1..7, or 0 when none of them is punched. `dma_byte`=1.
- R6: In packed mode, a column with more than one punch among rows 1..7 sets the format error (bit 11), issues no write and ends the transfer.
- R7: `dma_addr` = {extension, address}. After each acknowledged write this 18-bit value advances by 2 in word mode and by 1 in packed mode, with the carry flowing into the extension bits.
- R8: Each acknowledged write increments the count. The write that brings it to zero ends the transfer: ready=1 and start bit=0 in the cycle after the acknowledge.
- R9: A column strobe while a write is still outstanding sets the late flag (bit 10), withdraws the request and ends the transfer.
- R10: An error response (`dma_err` with the request) sets the memory-error flag (bit 9), ends the transfer and leaves the count and address unchanged.
- R11: Status bit 15 is the OR of bits 11, 10 and 9.
- R12: `irq` pulses for one cycle together with the rise of ready while interrupt enable is 1. It also pulses after any control write that sets interrupt enable while ready is already 1 and that write does not start a transfer.
- R13: Once raised, `dma_req` holds with stable address and data until acknowledge or error, unless a late strobe aborts it. A strobe while not busy is ignored.
- R14: The column buffer register holds the most recent accepted, formatted column, including a column rejected by R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| col_strobe | input | 1 | One-cycle column-valid pulse from the reader |
| col_zones | input | 12 | Zone punches of the column |
| rdr_offline | input | 1 | Reader offline status |
| rdr_online | input | 1 | Reader online status |
| rdr_hopper_chk | input | 1 | Reader hopper fault status |
| dma_req | output | 1 | Memory write request |
| dma_addr | output | 18 | Memory write address |
| dma_data | output | 16 | Memory write data |
| dma_byte | output | 1 | 1 = byte write, 0 = word write |
| dma_ack | input | 1 | Write completed |
| dma_err | input | 1 | Write failed (no memory) |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench sweeps all 4096 zone patterns in both formats. A packer that swapped rows, encoded the one-punch code off by one, or missed a double punch would produce a wrong byte, or a write where a format error is required. A directed transfer starts just below a 64K boundary. A design without the carry into the extension bits would wrap the third address to zero, and one with the wrong stride would show it in the second address. The error tests cover a late strobe, a failed write and a restart. A design that kept the request up after a late strobe, advanced the address on a failed write, or failed to clear stale flags at the next start is caught at the status register. Register writes during a transfer and strobes while idle are applied as well, to catch a design that lets either disturb its state.

// File: rtl/card_dma_pkg.sv
package card_dma_pkg;
   localparam int ST_READ    = 0;
   localparam int ST_PACK    = 1;
   localparam int ST_HOPPER  = 2;
   localparam int ST_ONLINE  = 3;
   localparam int ST_EXT_LO  = 4;
   localparam int ST_IE      = 6;
   localparam int ST_READY   = 7;
   localparam int ST_NXM     = 9;
   localparam int ST_LATE    = 10;
   localparam int ST_DERR    = 11;
   localparam int ST_OFFLINE = 12;
   localparam int ST_ERRSUM  = 15;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_ADDR  = 2'd2,
      SEL_BUF   = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic fmt_err;
      logic late;
      logic nxm;
   } err_flags_t;
endpackage

// File: rtl/card_col_fmt.sv
module card_col_fmt #(
   parameter int DW     = 16,
   parameter int ZONE_W = 12
) (
   input  logic [ZONE_W-1:0] zones,
   input  logic              pack,
   output logic [DW-1:0]     fmt,
   output logic              multi_punch
);
   localparam int SINGLE_ROWS = 7;
   localparam int CODE_W      = 3;

   if (ZONE_W != 12) begin : g_zone_bad
      $error("card_col_fmt: ZONE_W must be 12");
   end
   if (DW < ZONE_W) begin : g_dw_bad
      $error("card_col_fmt: DW must hold a raw column");
   end

   // hit[k-1] set when single-punch row k (1..7) is punched
   logic [SINGLE_ROWS-1:0] hit;
   for (genvar k = 1; k <= SINGLE_ROWS; k++) begin : g_hit
      assign hit[k-1] = zones[9-k];
   end

   logic [CODE_W-1:0] code;
   always_comb begin
      code = '0;
      for (int k = 1; k <= SINGLE_ROWS; k++) begin
         if (hit[k-1]) code = CODE_W'(k);
      end
   end

   assign multi_punch = ($countones(hit) > 1);

   logic [7:0] packed_byte;
   assign packed_byte = {zones[11], zones[10], zones[9], zones[0], zones[1], code};

   assign fmt = pack ? {{(DW-8){1'b0}}, packed_byte}
                     : {{(DW-ZONE_W){1'b0}}, zones};
endmodule

// File: rtl/card_xfer_engine.sv
module card_xfer_engine
   import card_dma_pkg::*;
#(
   parameter int DW    = 16,
   parameter int EXT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_count,
   input  logic             wr_addr,
   input  logic [DW-1:0]    wdata,
   input  logic             col_strobe,
   input  logic [DW-1:0]    col_fmt,
   input  logic             multi_punch,
   input  logic             dma_ack,
   input  logic             dma_err,
   output logic             ready,
   output logic             busy,
   output logic             pack,
   output logic [EXT_W-1:0] ext,
   output logic [DW-1:0]    count,
   output logic [DW-1:0]    addr,
   output logic [DW-1:0]    dbuf,
   output err_flags_t       errs,
   output logic             req,
   output logic             start,
   output logic             done
);
   localparam int XA_W = DW + EXT_W;

   logic             ready_q, busy_q, pack_q, req_q;
   logic [EXT_W-1:0] ext_q;
   logic [DW-1:0]    count_q, addr_q, dbuf_q;
   err_flags_t       errs_q;

   logic            accept, late_hit, fmt_err, ack_ok, nxm_hit, last_col;
   logic [DW-1:0]   cnt_nxt;
   logic [XA_W-1:0] xa_nxt;

   always_comb begin
      start    = wr_ctrl & wdata[ST_READ] & ready_q;
      accept   = busy_q & col_strobe & ~req_q;
      late_hit = busy_q & col_strobe & req_q;
      fmt_err  = accept & pack_q & multi_punch;
      ack_ok   = req_q & dma_ack & ~dma_err;
      nxm_hit  = req_q & dma_err;
      cnt_nxt  = count_q + DW'(1);
      xa_nxt   = {ext_q, addr_q} + (pack_q ? XA_W'(1) : XA_W'(2));
      last_col = ack_ok & (cnt_nxt == '0);
      done     = busy_q & (late_hit | fmt_err | nxm_hit | last_col);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b1;
         busy_q  <= 1'b0;
         pack_q  <= 1'b0;
         req_q   <= 1'b0;
         ext_q   <= '0;
         count_q <= '0;
         addr_q  <= '0;
         dbuf_q  <= '0;
         errs_q  <= '0;
      end else if (ready_q) begin
         if (wr_count) count_q <= wdata;
         if (wr_addr)  addr_q  <= wdata;
         if (wr_ctrl) begin
            ext_q  <= wdata[ST_EXT_LO +: EXT_W];
            pack_q <= wdata[ST_PACK];
         end
         if (start) begin
            ready_q <= 1'b0;
            busy_q  <= 1'b1;
            errs_q  <= '0;
         end
      end else begin
         if (accept) dbuf_q <= col_fmt;
         if (accept && !fmt_err) req_q <= 1'b1;
         if (ack_ok || nxm_hit || late_hit) req_q <= 1'b0;
         if (ack_ok) begin
            count_q         <= cnt_nxt;
            {ext_q, addr_q} <= xa_nxt;
         end
         if (fmt_err)  errs_q.fmt_err <= 1'b1;
         if (late_hit) errs_q.late    <= 1'b1;
         if (nxm_hit)  errs_q.nxm     <= 1'b1;
         if (done) begin
            ready_q <= 1'b1;
            busy_q  <= 1'b0;
         end
      end
   end

   assign ready = ready_q;
   assign busy  = busy_q;
   assign pack  = pack_q;
   assign ext   = ext_q;
   assign count = count_q;
   assign addr  = addr_q;
   assign dbuf  = dbuf_q;
   assign errs  = errs_q;
   assign req   = req_q;
endmodule

// File: rtl/card_irq_gen.sv
module card_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ctrl,
   input  logic ie_wdata,
   input  logic ready,
   input  logic start,
   input  logic done,
   output logic ie,
   output logic irq
);
   logic ie_q, irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (wr_ctrl) ie_q <= ie_wdata;
         irq_q <= (done & ie_q) | (wr_ctrl & ie_wdata & ready & ~start);
      end
   end

   assign ie  = ie_q;
   assign irq = irq_q;
endmodule

// File: rtl/card_dma_ctrl.sv
module card_dma_ctrl
   import card_dma_pkg::*;
#(
   parameter int DW     = 16,
   parameter int EXT_W  = 2,
   parameter int ZONE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          reg_sel,
   input  logic                reg_wr,
   input  logic [DW-1:0]       reg_wdata,
   output logic [DW-1:0]       reg_rdata,
   input  logic                col_strobe,
   input  logic [ZONE_W-1:0]   col_zones,
   input  logic                rdr_offline,
   input  logic                rdr_online,
   input  logic                rdr_hopper_chk,
   output logic                dma_req,
   output logic [DW+EXT_W-1:0] dma_addr,
   output logic [DW-1:0]       dma_data,
   output logic                dma_byte,
   input  logic                dma_ack,
   input  logic                dma_err,
   output logic                irq
);
   if (DW != 16) begin : g_dw_bad
      $error("card_dma_ctrl: status layout needs DW == 16");
   end
   if (EXT_W != 2) begin : g_ext_bad
      $error("card_dma_ctrl: status layout needs EXT_W == 2");
   end

   logic wr_ctrl, wr_count, wr_addr;
   assign wr_ctrl  = reg_wr & (reg_sel == SEL_CTRL);
   assign wr_count = reg_wr & (reg_sel == SEL_COUNT);
   assign wr_addr  = reg_wr & (reg_sel == SEL_ADDR);

   logic [DW-1:0]    fmt_w, count_w, addr_w, dbuf_w;
   logic             multi_w, ready_w, busy_w, pack_w, req_w, start_w, done_w, ie_w;
   logic [EXT_W-1:0] ext_w;
   err_flags_t       errs_w;

   card_col_fmt #(.DW(DW), .ZONE_W(ZONE_W)) u_fmt (
      .zones       (col_zones),
      .pack        (pack_w),
      .fmt         (fmt_w),
      .multi_punch (multi_w)
   );

   card_xfer_engine #(.DW(DW), .EXT_W(EXT_W)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ctrl     (wr_ctrl),
      .wr_count    (wr_count),
      .wr_addr     (wr_addr),
      .wdata       (reg_wdata),
      .col_strobe  (col_strobe),
      .col_fmt     (fmt_w),
      .multi_punch (multi_w),
      .dma_ack     (dma_ack),
      .dma_err     (dma_err),
      .ready       (ready_w),
      .busy        (busy_w),
      .pack        (pack_w),
      .ext         (ext_w),
      .count       (count_w),
      .addr        (addr_w),
      .dbuf        (dbuf_w),
      .errs        (errs_w),
      .req         (req_w),
      .start       (start_w),
      .done        (done_w)
   );

   card_irq_gen u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .ie_wdata (reg_wdata[ST_IE]),
      .ready    (ready_w),
      .start    (start_w),
      .done     (done_w),
      .ie       (ie_w),
      .irq      (irq)
   );

   logic [DW-1:0] status;
   always_comb begin
      status                          = '0;
      status[ST_ERRSUM]               = errs_w.fmt_err | errs_w.late | errs_w.nxm;
      status[ST_OFFLINE]              = rdr_offline;
      status[ST_DERR]                 = errs_w.fmt_err;
      status[ST_LATE]                 = errs_w.late;
      status[ST_NXM]                  = errs_w.nxm;
      status[ST_READY]                = ready_w;
      status[ST_IE]                   = ie_w;
      status[ST_EXT_LO +: EXT_W]      = ext_w;
      status[ST_ONLINE]               = rdr_online;
      status[ST_HOPPER]               = rdr_hopper_chk;
      status[ST_PACK]                 = pack_w;
      status[ST_READ]                 = busy_w;
   end

   always_comb begin
      unique case (reg_sel)
         SEL_CTRL:  reg_rdata = status;
         SEL_COUNT: reg_rdata = count_w;
         SEL_ADDR:  reg_rdata = addr_w;
         default:   reg_rdata = dbuf_w;
      endcase
   end

   assign dma_req  = req_w;
   assign dma_addr = {ext_w, addr_w};
   assign dma_data = dbuf_w;
   assign dma_byte = pack_w;
endmodule

// File: rtl/card_dma_ctrl_chk.sv
module card_dma_ctrl_chk #(
   parameter int DW    = 16,
   parameter int EXT_W = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                dma_req,
   input logic                dma_ack,
   input logic                dma_err,
   input logic                col_strobe,
   input logic [DW+EXT_W-1:0] dma_addr,
   input logic [DW-1:0]       dma_data,
   input logic                irq,
   input logic                ready,
   input logic                busy,
   input logic [DW-1:0]       count,
   input logic                nxm
);
   // R3
   ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && busy));

   // R13
   req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> !ready);

   // R13
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && !dma_ack && !dma_err && !col_strobe)
      |=> (dma_req && $stable(dma_addr) && $stable(dma_data)));

   // R8
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && dma_ack && !dma_err) |=> (count == $past(count) + DW'(1)));

   // R10
   nxm_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && dma_err) |=> (ready && nxm && !dma_req));

   // R9
   late_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && col_strobe) |=> (!dma_req && ready));

   // R12
   irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ready);
endmodule

bind card_dma_ctrl card_dma_ctrl_chk #(.DW(DW), .EXT_W(EXT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dma_req    (dma_req),
   .dma_ack    (dma_ack),
   .dma_err    (dma_err),
   .col_strobe (col_strobe),
   .dma_addr   (dma_addr),
   .dma_data   (dma_data),
   .irq        (irq),
   .ready      (ready_w),
   .busy       (busy_w),
   .count      (count_w),
   .nxm        (errs_w.nxm)
);

// File: tb/card_dma_ctrl_tb.sv
module card_dma_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        col_strobe = 1'b0;
   logic [11:0] col_zones = '0;
   logic        rdr_offline = 1'b0, rdr_online = 1'b0, rdr_hopper_chk = 1'b0;
   logic        dma_req;
   logic [17:0] dma_addr;
   logic [15:0] dma_data;
   logic        dma_byte;
   logic        dma_ack = 1'b0, dma_err = 1'b0;
   logic        irq;

   int n_checks = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   card_dma_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .col_strobe(col_strobe),
      .col_zones(col_zones), .rdr_offline(rdr_offline), .rdr_online(rdr_online),
      .rdr_hopper_chk(rdr_hopper_chk), .dma_req(dma_req), .dma_addr(dma_addr),
      .dma_data(dma_data), .dma_byte(dma_byte), .dma_ack(dma_ack),
      .dma_err(dma_err), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] s, input logic [15:0] d);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [15:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   task automatic strobe(input logic [11:0] z);
      col_zones = z; col_strobe = 1'b1;
      tick();
      col_strobe = 1'b0;
   endtask

   task automatic ack();
      dma_ack = 1'b1;
      tick();
      dma_ack = 1'b0;
   endtask

   function automatic logic [15:0] exp_fmt(input bit p, input logic [11:0] z);
      logic [2:0] code;
      if (!p) return {4'b0, z};
      code = 3'd0;
      for (int k = 1; k <= 7; k++) if (z[9-k]) code = 3'(k);
      return {8'b0, z[11], z[10], z[9], z[0], z[1], code};
   endfunction

   function automatic bit exp_multi(input logic [11:0] z);
      return $countones(z[8:2]) > 1;
   endfunction

   // one single-column transfer per zone pattern, address 0x1000
   task automatic run_col(input bit p, input logic [11:0] z);
      logic [15:0] v;
      logic [15:0] e;
      e = exp_fmt(p, z);
      wr(2'd1, 16'hFFFF);
      wr(2'd2, 16'h1000);
      wr(2'd0, 16'h0041 | (p ? 16'h0002 : 16'h0000));
      strobe(z);
      if (p && exp_multi(z)) begin
         check("R6 no write on multi-punch", {31'b0, dma_req}, 32'd0);
         rd(2'd0, v);
         check("R6 format error bit", {31'b0, v[11]}, 32'd1);
         check("R11 error summary", {31'b0, v[15]}, 32'd1);
         check("R6 ready after abort", {31'b0, v[7]}, 32'd1);
         check("R12 irq on abort", {31'b0, irq}, 32'd1);
         rd(2'd3, v);
         check("R14 buffer keeps rejected column", {16'b0, v}, {16'b0, e});
      end else begin
         check(p ? "R5 request" : "R4 request", {31'b0, dma_req}, 32'd1);
         check(p ? "R5 packed data" : "R4 word data", {16'b0, dma_data}, {16'b0, e});
         check("R7 address", {14'b0, dma_addr}, 32'h0000_1000);
         check("R4 R5 byte flag", {31'b0, dma_byte}, {31'b0, p});
         ack();
         check("R8 request drops", {31'b0, dma_req}, 32'd0);
         check("R12 irq on completion", {31'b0, irq}, 32'd1);
         rd(2'd0, v);
         check("R8 ready and idle", {30'b0, v[7], v[0]}, 32'd2);
         check("R11 no error", {28'b0, v[15], v[11:9]}, 32'd0);
         rd(2'd1, v);
         check("R8 count zero", {16'b0, v}, 32'd0);
         rd(2'd2, v);
         check("R7 address step", {16'b0, v}, p ? 32'h1001 : 32'h1002);
         rd(2'd3, v);
         check("R14 buffer", {16'b0, v}, {16'b0, e});
         tick();
         check("R12 irq one cycle", {31'b0, irq}, 32'd0);
      end
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [17:0] a0;
      tick(); tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      rd(2'd0, v); check("R1 status after reset", {16'b0, v}, 32'h0080);
      rd(2'd1, v); check("R1 count after reset", {16'b0, v}, 32'd0);
      rd(2'd2, v); check("R1 address after reset", {16'b0, v}, 32'd0);
      rd(2'd3, v); check("R1 buffer after reset", {16'b0, v}, 32'd0);
      check("R1 no request", {31'b0, dma_req}, 32'd0);
      check("R1 no irq", {31'b0, irq}, 32'd0);

      // R2 mirrors and read-only bits; R12 irq on enable while ready
      rdr_offline = 1'b1; rdr_online = 1'b1; rdr_hopper_chk = 1'b1;
      rd(2'd0, v); check("R2 mirrors", {16'b0, v}, 32'h108C);
      wr(2'd0, 16'hFFFE);
      check("R12 irq on enable write", {31'b0, irq}, 32'd1);
      rd(2'd0, v); check("R2 read-only bits ignored", {16'b0, v}, 32'h10FE);
      tick();
      check("R12 irq single pulse", {31'b0, irq}, 32'd0);
      rdr_offline = 1'b0; rdr_online = 1'b0; rdr_hopper_chk = 1'b0;
      wr(2'd0, 16'h0000);
      check("R12 no irq when enable cleared", {31'b0, irq}, 32'd0);

      // R7 R8 carry across 64K, R3 writes ignored while busy, R13 hold
      wr(2'd1, 16'hFFFD);
      wr(2'd2, 16'hFFFC);
      wr(2'd0, 16'h0001);
      rd(2'd0, v); check("R3 busy after start", {30'b0, v[7], v[0]}, 32'd1);
      wr(2'd1, 16'h1234);
      wr(2'd2, 16'h5555);
      wr(2'd0, 16'h0033);
      rd(2'd1, v); check("R3 count write ignored", {16'b0, v}, 32'hFFFD);
      rd(2'd2, v); check("R3 address write ignored", {16'b0, v}, 32'hFFFC);
      rd(2'd0, v); check("R3 mode write ignored", {26'b0, v[5:4], v[1], v[7], v[0], 1'b0}, 32'd2);
      strobe(12'hA5A);
      check("R7 first address", {14'b0, dma_addr}, 32'h0_FFFC);
      check("R4 first data", {16'b0, dma_data}, 32'h0A5A);
      a0 = dma_addr;
      for (int i = 0; i < 3; i++) begin
         tick();
         check("R13 request held", {31'b0, dma_req}, 32'd1);
         check("R13 address stable", {14'b0, dma_addr}, {14'b0, a0});
         check("R13 data stable", {16'b0, dma_data}, 32'h0A5A);
      end
      ack();
      rd(2'd1, v); check("R8 count after first", {16'b0, v}, 32'hFFFE);
      rd(2'd0, v); check("R8 still busy", {30'b0, v[7], v[0]}, 32'd1);
      strobe(12'h001);
      check("R7 second address", {14'b0, dma_addr}, 32'h0_FFFE);
      ack();
      strobe(12'h800);
      check("R7 carry into extension", {14'b0, dma_addr}, 32'h1_0000);
      ack();
      check("R12 no irq when disabled", {31'b0, irq}, 32'd0);
      rd(2'd0, v); check("R8 ready at zero", {30'b0, v[7], v[0]}, 32'd2);
      check("R7 extension bits", {30'b0, v[5:4]}, 32'd1);
      rd(2'd2, v); check("R7 low address", {16'b0, v}, 32'h0002);
      rd(2'd1, v); check("R8 count reached zero", {16'b0, v}, 32'd0);

      // R13 strobe while idle ignored
      strobe(12'hFFF);
      check("R13 no request when idle", {31'b0, dma_req}, 32'd0);
      rd(2'd3, v); check("R13 buffer unchanged when idle", {16'b0, v}, 32'h0800);

      // R9 data late
      wr(2'd1, 16'hFFFE);
      wr(2'd2, 16'h2000);
      wr(2'd0, 16'h0001);
      strobe(12'h123);
      check("R9 first request", {31'b0, dma_req}, 32'd1);
      strobe(12'h456);
      check("R9 request withdrawn", {31'b0, dma_req}, 32'd0);
      rd(2'd0, v);
      check("R9 late flag", {31'b0, v[10]}, 32'd1);
      check("R11 summary on late", {31'b0, v[15]}, 32'd1);
      check("R9 ready after late", {30'b0, v[7], v[0]}, 32'd2);
      rd(2'd3, v); check("R14 late column not taken", {16'b0, v}, 32'h0123);
      rd(2'd1, v); check("R9 count unchanged", {16'b0, v}, 32'hFFFE);

      // R3 restart clears errors, R10 memory error
      wr(2'd0, 16'h0001);
      rd(2'd0, v); check("R3 errors cleared on start", {28'b0, v[15], v[11:9]}, 32'd0);
      strobe(12'h321);
      dma_err = 1'b1;
      tick();
      dma_err = 1'b0;
      check("R10 request drops", {31'b0, dma_req}, 32'd0);
      rd(2'd0, v);
      check("R10 memory error flag", {31'b0, v[9]}, 32'd1);
      check("R11 summary on memory error", {31'b0, v[15]}, 32'd1);
      check("R10 ready", {31'b0, v[7]}, 32'd1);
      rd(2'd2, v); check("R10 address unchanged", {16'b0, v}, 32'h2000);
      rd(2'd1, v); check("R10 count unchanged", {16'b0, v}, 32'hFFFE);

      // R4 R5 R6 exhaustive sweep
      for (int p = 0; p < 2; p++) begin
         for (int z = 0; z < 4096; z++) begin
            run_col(p[0], 12'(z));
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule